// File: doc/BRIEF.md
# Multi-Lane Shift-Register Output Driver

This block drives a bank of discrete outputs through several external serial-in, parallel-out shift registers. Each register chain has its own data lane and its own storage latch line, and all chains share one shift clock and one clear line. The block keeps one byte-wide image entry per lane. A simple write port fills the entries. Any accepted write marks the image as pending.

When an update is pending and the sequencer is idle, the block copies the whole image into per-lane shift buffers and drops every latch line. It then clocks the bytes out in lockstep, most significant bit first, at a shift-clock rate set by a half-period divider. After the last bit it raises all latch lines together, and that edge moves the chain contents onto the external outputs. Writes made during an update never reach the frame on the wire. They schedule a follow-up update instead.

After reset the block runs a fixed power-up order. The outputs stay disabled, the data lanes are low, the latches idle high and the image is zero. Next the shared clear line is pulsed low and released. Only after that is the active-low output enable driven low.

Top module: `shiftchain_out_drv`

## Requirements
- R1: While reset is held, `out_en_n` is 1, `sr_clr_n` is 1, every `sr_latch` bit is 1, every `sr_data` bit is 0, `sr_clk` is 0 and `busy` is 0. Every image byte resets to zero.
- R2: After reset is released, `sr_clr_n` stays high for HALF_DIV cycles and then goes low for HALF_DIV cycles. It then returns high, and HALF_DIV cycles later `out_en_n` falls. No update starts before `out_en_n` is low.
- R3: A write with `wr_en` high and `wr_idx` below N_LANES stores `wr_data` as the byte for lane `wr_idx` and marks an update pending. A write with `wr_idx` of N_LANES or more changes nothing and starts no update.
- R4: One cycle after a pending write is committed, if the sequencer is idle, `busy` rises and all latch lines fall on the same edge. The frame sent is the image as it stood before that edge.
- R5: Each update gives exactly LANE_W rising edges of `sr_clk`. At each rising edge, lane n carries one bit of byte n, from bit LANE_W-1 down to bit 0, and all lanes advance together.
- R6: During an update, `sr_clk` spends HALF_DIV cycles low and then HALF_DIV cycles high for every bit. The data lanes change only as `sr_clk` falls or at start, and they are stable while it is high. `sr_clk` is low whenever `busy` is low.
- R7: After the last high phase, on a single edge, all latch lines rise together, `sr_clk` returns low, `busy` falls and all data lanes return to 0.
- R8: A write accepted while an update is running does not alter the frame being shifted.
- R9: A write committed on the start edge or during an update causes exactly one further update after the current one. Several writes committed before a start are sent in a single update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Image write strobe |
| wr_idx | input | IDX_W | Lane index of the byte written |
| wr_data | input | LANE_W | Byte value written |
| busy | output | 1 | High from the snapshot edge until the latch edge |
| sr_clk | output | 1 | Shared shift clock to all chains |
| sr_clr_n | output | 1 | Shared active-low chain clear |
| out_en_n | output | 1 | Active-low output enable of all chains |
| sr_data | output | N_LANES | Serial data, one bit per lane |
| sr_latch | output | N_LANES | Storage latch strobes, one per lane |

## Verification
The bench builds the block with five lanes of eight bits and a half-period of three system clocks. With three clocks, a wrong phase length cannot pass as a one-clock error. The bench models the external chains from the pin edges and compares each latched 40-bit frame against a scoreboard of expected frames. Back-to-back writes from idle and writes in the middle of a shift exercise the snapshot and re-trigger rules. With five lanes the three-bit index has the out-of-range codes 5 to 7, so the rule for ignored writes can be reached from the port.

// File: rtl/msr_pkg.sv
package msr_pkg;
   typedef enum logic [2:0] {
      ST_SETUP,
      ST_CLR,
      ST_REL,
      ST_IDLE,
      ST_LO,
      ST_HI
   } seq_st_t;
endpackage

// File: rtl/msr_timer.sv
module msr_timer #(
   parameter int HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

   logic [CW-1:0] cnt_q;

   assign tick = (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST); // R6
endmodule

// File: rtl/msr_image.sv
module msr_image #(
   parameter int N_LANES = 5,
   parameter int LANE_W  = 8,
   parameter int IDX_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_idx,
   input  logic [LANE_W-1:0]         wr_data,
   input  logic                      take,
   output logic [N_LANES*LANE_W-1:0] image_flat,
   output logic                      pending
);
   localparam logic [IDX_W:0] LIM = (IDX_W+1)'(N_LANES);

   logic wr_ok;
   logic pend_q;

   assign wr_ok   = wr_en && ({1'b0, wr_idx} < LIM);
   assign pending = pend_q;

   for (genvar g = 0; g < N_LANES; g++) begin : g_entry
      logic [LANE_W-1:0] img_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            img_q <= '0;
         else if (wr_ok && (wr_idx == IDX_W'(g)))
            img_q <= wr_data;
      end
      assign image_flat[g*LANE_W +: LANE_W] = img_q;
   end

   // a write on the snapshot edge wins over the clear
   always_ff @(posedge clk) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (wr_ok)
         pend_q <= 1'b1;
      else if (take)
         pend_q <= 1'b0;
   end

   AST_WR_MARKS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_idx} < LIM)) |=> pend_q); // R9
   AST_BAD_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && ({1'b0, wr_idx} >= LIM) && !pend_q) |=> !pend_q); // R3
   AST_TAKE_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend_q); // R4
endmodule

// File: rtl/msr_lanes.sv
module msr_lanes #(
   parameter int N_LANES = 5,
   parameter int LANE_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      load,
   input  logic                      advance,
   input  logic [N_LANES*LANE_W-1:0] image_flat,
   output logic [N_LANES-1:0]        lane_bits
);
   for (genvar g = 0; g < N_LANES; g++) begin : g_lane
      logic [LANE_W-1:0] sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            sh_q <= '0;
         else if (load)
            sh_q <= image_flat[g*LANE_W +: LANE_W];
         else if (advance)
            sh_q <= {sh_q[LANE_W-2:0], 1'b0};
      end
      assign lane_bits[g] = sh_q[LANE_W-1];
   end

   AST_LOAD_ADV_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && advance)); // R4
endmodule

// File: rtl/msr_seq.sv
module msr_seq
   import msr_pkg::*;
#(
   parameter int LANE_W = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic pending,
   output logic hold,
   output logic take,
   output logic advance,
   output logic busy,
   output logic sclk,
   output logic clr_n,
   output logic oen_n,
   output logic latch
);
   localparam int BW = $clog2(LANE_W);
   localparam logic [BW-1:0] LAST_BIT = BW'(LANE_W - 1);

   seq_st_t       state_q;
   logic [BW-1:0] bit_q;
   logic          sclk_q, clr_q, oen_q, latch_q;

   assign hold    = (state_q == ST_IDLE);
   assign take    = hold && pending;
   assign advance = (state_q == ST_HI) && tick;
   assign busy    = (state_q == ST_LO) || (state_q == ST_HI);
   assign sclk    = sclk_q;
   assign clr_n   = clr_q;
   assign oen_n   = oen_q;
   assign latch   = latch_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_SETUP;
         bit_q   <= '0;
         sclk_q  <= 1'b0;
         clr_q   <= 1'b1;
         oen_q   <= 1'b1;
         latch_q <= 1'b1;
      end else begin
         case (state_q)
            ST_SETUP: if (tick) begin
               state_q <= ST_CLR;
               clr_q   <= 1'b0;
            end
            ST_CLR: if (tick) begin
               state_q <= ST_REL;
               clr_q   <= 1'b1;
            end
            ST_REL: if (tick) begin
               state_q <= ST_IDLE;
               oen_q   <= 1'b0;
            end
            ST_IDLE: if (pending) begin
               state_q <= ST_LO;
               latch_q <= 1'b0;
               bit_q   <= '0;
            end
            ST_LO: if (tick) begin
               state_q <= ST_HI;
               sclk_q  <= 1'b1;
            end
            ST_HI: if (tick) begin
               sclk_q <= 1'b0;
               if (bit_q == LAST_BIT) begin
                  state_q <= ST_IDLE;
                  latch_q <= 1'b1;
               end else begin
                  state_q <= ST_LO;
                  bit_q   <= bit_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   logic clr_seen_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         clr_seen_q <= 1'b0;
      else if (!clr_q)
         clr_seen_q <= 1'b1;
   end

   AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk_q); // R6
   AST_LATCH_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !latch_q); // R4
   AST_NO_SHIFT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !oen_q); // R2
   AST_EN_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(oen_q) |-> (clr_q && clr_seen_q)); // R2
   AST_LATCH_EDGE_END: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(latch_q) |-> (!busy && !sclk_q)); // R7
endmodule

// File: rtl/shiftchain_out_drv.sv
module shiftchain_out_drv #(
   parameter int N_LANES  = 5,
   parameter int LANE_W   = 8,
   parameter int HALF_DIV = 4,
   parameter int IDX_W    = (N_LANES > 1) ? $clog2(N_LANES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [LANE_W-1:0]  wr_data,
   output logic               busy,
   output logic               sr_clk,
   output logic               sr_clr_n,
   output logic               out_en_n,
   output logic [N_LANES-1:0] sr_data,
   output logic [N_LANES-1:0] sr_latch
);
   if (N_LANES < 1) begin : g_bad_lanes
      $error("N_LANES must be at least 1");
   end
   if (LANE_W < 2) begin : g_bad_width
      $error("LANE_W must be at least 2");
   end
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end
   if ((1 << IDX_W) < N_LANES) begin : g_bad_idx
      $error("IDX_W too narrow for N_LANES");
   end

   logic [N_LANES*LANE_W-1:0] image_flat;
   logic pending, take, advance, hold, tick, latch;

   msr_image #(.N_LANES(N_LANES), .LANE_W(LANE_W), .IDX_W(IDX_W)) u_image (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_data    (wr_data),
      .take       (take),
      .image_flat (image_flat),
      .pending    (pending)
   );

   msr_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (hold),
      .tick  (tick)
   );

   msr_seq #(.LANE_W(LANE_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .pending (pending),
      .hold    (hold),
      .take    (take),
      .advance (advance),
      .busy    (busy),
      .sclk    (sr_clk),
      .clr_n   (sr_clr_n),
      .oen_n   (out_en_n),
      .latch   (latch)
   );

   msr_lanes #(.N_LANES(N_LANES), .LANE_W(LANE_W)) u_lanes (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (take),
      .advance    (advance),
      .image_flat (image_flat),
      .lane_bits  (sr_data)
   );

   for (genvar g = 0; g < N_LANES; g++) begin : g_latch
      assign sr_latch[g] = latch;
   end

   AST_DATA_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sr_clk && $past(sr_clk)) |-> $stable(sr_data)); // R6
   AST_IDLE_DATA_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (sr_data == '0)); // R7
endmodule

// File: tb/tb_shiftchain_out_drv.sv
module tb_shiftchain_out_drv;
   localparam int N   = 5;
   localparam int W   = 8;
   localparam int DIV = 3;
   localparam int IW  = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, wr_en;
   logic [IW-1:0] wr_idx;
   logic [W-1:0]  wr_data;
   logic          busy, sr_clk, sr_clr_n, out_en_n;
   logic [N-1:0]  sr_data, sr_latch;

   shiftchain_out_drv #(.N_LANES(N), .LANE_W(W), .HALF_DIV(DIV), .IDX_W(IW)) dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .busy(busy), .sr_clk(sr_clk), .sr_clr_n(sr_clr_n), .out_en_n(out_en_n),
      .sr_data(sr_data), .sr_latch(sr_latch)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // scoreboard
   logic [W-1:0]   img_m [N];
   logic [N*W-1:0] exp_q [$];
   string          tag_q [$];

   function automatic logic [N*W-1:0] pack_model();
      logic [N*W-1:0] f;
      for (int l = 0; l < N; l++) f[l*W +: W] = img_m[l];
      return f;
   endfunction

   task automatic push_frame(input string tag);
      exp_q.push_back(pack_model());
      tag_q.push_back(tag);
   endtask

   task automatic wr(input int idx, input logic [W-1:0] d);
      wr_en   = 1'b1;
      wr_idx  = IW'(idx);
      wr_data = d;
      if (idx < N) img_m[idx] = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_quiet();
      int q = 0;
      while (q < 4) begin
         @(negedge clk);
         if (busy) q = 0; else q++;
      end
   endtask

   // monitor: models the external chains from pin edges
   logic [W-1:0] chain [N];
   logic [W-1:0] store [N];
   logic         p_sclk, p_clr, p_oen, p_busy;
   logic [N-1:0] p_latch, p_data;
   int high_cnt = 0, clr_cnt = 0, gap_cnt = 0, nrise = 0;
   int n_upd = 0, n_busy_rise = 0;

   always @(negedge clk) begin
      if (!rst_n) begin
         p_sclk = 1'b0; p_clr = 1'b1; p_oen = 1'b1; p_busy = 1'b0;
         p_latch = '1; p_data = '0;
         for (int l = 0; l < N; l++) begin chain[l] = '0; store[l] = '0; end
      end else begin
         if (!sr_clr_n) for (int l = 0; l < N; l++) chain[l] = '0;
         if (!sr_clr_n && p_clr) begin
            check(out_en_n == 1'b1, "R2", "enable off when clear falls", out_en_n, 1);
            clr_cnt = 1;
         end else if (!sr_clr_n) clr_cnt++;
         if (sr_clr_n && !p_clr) begin
            check(clr_cnt == DIV, "R2", "clear low length", clr_cnt, DIV);
            gap_cnt = 1;
         end else if (out_en_n) gap_cnt++;
         if (!out_en_n && p_oen) begin
            check(gap_cnt == DIV, "R2", "clear release to enable", gap_cnt, DIV);
            check(sr_clr_n == 1'b1, "R2", "clear high at enable", sr_clr_n, 1);
         end
         if (busy && !p_busy) begin
            n_busy_rise++;
            nrise = 0;
            check(sr_latch == '0, "R4", "latches low at start", sr_latch, 0);
            check(!out_en_n, "R2", "enable on at first update", out_en_n, 0);
         end
         if (sr_clk && !p_sclk) begin
            nrise++;
            high_cnt = 1;
            for (int l = 0; l < N; l++) chain[l] = {chain[l][W-2:0], sr_data[l]};
         end else if (sr_clk) begin
            high_cnt++;
            if (sr_data != p_data)
               check(1'b0, "R6", "data moved while shift clock high", sr_data, p_data);
         end
         if (!sr_clk && p_sclk)
            check(high_cnt == DIV, "R6", "shift clock high length", high_cnt, DIV);
         if (sr_latch != '0 && p_latch == '0) begin
            logic [N*W-1:0] got, want;
            string tg;
            check(sr_latch == '1, "R7", "latches rise together", sr_latch, '1);
            check(!busy, "R7", "busy low at latch edge", busy, 0);
            check(!sr_clk, "R7", "shift clock low at latch edge", sr_clk, 0);
            check(sr_data == '0, "R7", "lanes low after update", sr_data, 0);
            check(nrise == W, "R5", "shift edges per update", nrise, W);
            for (int l = 0; l < N; l++) begin
               store[l] = chain[l];
               got[l*W +: W] = chain[l];
            end
            n_upd++;
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "unexpected update", got, 0);
            end else begin
               want = exp_q.pop_front();
               tg   = tag_q.pop_front();
               check(got == want, tg, "latched frame", got, want);
            end
         end
         p_sclk = sr_clk; p_clr = sr_clr_n; p_oen = out_en_n; p_busy = busy;
         p_latch = sr_latch; p_data = sr_data;
      end
   end

   task automatic report();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
   end

   initial begin
      int base, brise, t;
      rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
      for (int l = 0; l < N; l++) img_m[l] = '0;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(out_en_n == 1'b1, "R1", "enable off in reset", out_en_n, 1);
      check(sr_clr_n == 1'b1, "R1", "clear idle in reset", sr_clr_n, 1);
      check(sr_latch == '1, "R1", "latches high in reset", sr_latch, '1);
      check(sr_data == '0, "R1", "lanes low in reset", sr_data, 0);
      check(sr_clk == 1'b0 && busy == 1'b0, "R1", "clock and busy low", {sr_clk, busy}, 0);
      rst_n = 1'b1;
      t = 0;
      while (out_en_n && t < 200) begin @(negedge clk); t++; end
      check(!out_en_n, "R2", "enable asserted after init", out_en_n, 0);
      check(n_upd == 0 && n_busy_rise == 0, "R2", "no update during init", n_upd, 0);

      // R1: cleared image shows up in first frame; R3 lane mapping
      wr(0, 8'hA5);
      push_frame("R1");
      wait_quiet();
      check(n_upd == 1, "R3", "one update per write", n_upd, 1);

      // R9: back-to-back writes, start edge picks only the first
      base = n_upd;
      wr(0, 8'h81);
      push_frame("R4");
      wr(1, 8'h42);
      wr(2, 8'h3C);
      wr(3, 8'hF0);
      wr(4, 8'h0F);
      push_frame("R9");
      wait_quiet();
      check(n_upd == base + 2, "R9", "re-triggered update count", n_upd, base + 2);

      // R8: write during shifting leaves current frame intact
      base = n_upd;
      wr(2, 8'h55);
      push_frame("R8");
      t = 0;
      while (!busy && t < 50) begin @(negedge clk); t++; end
      repeat (4) @(negedge clk);
      wr(2, 8'hAA);
      push_frame("R9");
      wait_quiet();
      check(n_upd == base + 2, "R8", "mid-shift write gives one more update", n_upd, base + 2);

      // R3: out-of-range indices ignored
      base  = n_upd;
      brise = n_busy_rise;
      wr(5, 8'hFF);
      wr(7, 8'hFF);
      repeat (20) @(negedge clk);
      check(n_busy_rise == brise, "R3", "bad index starts no update", n_busy_rise, brise);
      check(n_upd == base, "R3", "bad index latches nothing", n_upd, base);
      wr(1, 8'h11);
      push_frame("R3");
      wait_quiet();

      check(exp_q.size() == 0, "R5", "all expected frames latched", exp_q.size(), 0);
      report();
   end
endmodule